// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches an asynchronous serial line for a break condition: the line held at its active-low level for at least as long as one whole frame. It runs alongside the frame receiver. It looks only at raw transitions of the line and does not follow the receiver's bit-sampling sequence. A falling edge starts a measurement. On the following rising edge the block compares the elapsed low time with a threshold that it derives from the configured frame format. That format is one start bit, the data bits, an optional parity bit, and a stop length given in half-bit steps.

A break is reported once the line has returned high, never while it is still low. The report is a single-cycle pulse. A second output carries a matching one-cycle request that sends the frame receiver back to its idle state, where it waits for a start bit. The line input is expected to be synchronised already. A polarity control inverts it before any edge is detected.

Top module: `line_break_detector`

## Requirements
- R1: While reset is held and in the first cycle after it, `break_o` and `rx_idle_req_o` are low.
- R2: If the line (after polarity correction) rises after a low interval of L clock samples, with L at least the threshold T, `break_o` is high for the cycle that follows the clock edge which sampled the rise.
- R3: A low interval of T-1 samples or fewer, ended by a rise, produces no pulse.
- R4: T = ceil((1 + data_bits_i + parity_en_i + stop_halves_i/2) × clks_per_bit_i). `data_bits_i` is the bit count (5 to 9). `parity_en_i`=1 adds one bit. `stop_halves_i` is 0, 1, 2 or 3, meaning 0, 0.5, 1 or 1.5 bit times.
- R5: Each break produces exactly one high cycle on `break_o`.
- R6: `rx_idle_req_o` is high in exactly the cycles where `break_o` is high.
- R7: Each rising edge clears the measurement. Two short low intervals separated by a brief high are each judged on their own and do not add up.
- R8: With `invert_i`=1 the line is inverted before detection, so a long high level on `line_i` that ends with a fall is a break.
- R9: A low interval much longer than T, including thousands of samples, still yields exactly one pulse. The counter saturates and never wraps.
- R10: A rise with no falling edge since reset, such as a line that was low through reset, produces no pulse.
- R11: No pulse is issued while the line is still low, however long the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Synchronised serial line |
| invert_i | input | 1 | 1: invert line polarity before detection |
| data_bits_i | input | 4 | Data bits per frame (5..9) |
| parity_en_i | input | 1 | 1: frame carries a parity bit |
| stop_halves_i | input | 2 | Stop length in half-bit units (0..3) |
| clks_per_bit_i | input | CPB_W | Clock samples per bit, at least 1 |
| break_o | output | 1 | One-cycle break pulse |
| rx_idle_req_o | output | 1 | One-cycle request to return the frame receiver to idle |

## Verification
The bench keeps the default divisor width of 16 bits. It drives small divisors of 3, 4 and 5 so that each frame lasts only a few dozen samples. This makes the exact threshold, and the sample one below it, cheap to reach for several formats. An odd divisor combined with a half or one-and-a-half stop length makes the threshold a rounded-up fraction, which exercises the half-bit arithmetic. A 2000-sample low interval drives the counter far past saturation.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

    // Width of the half-bit frame length: 2*(1 + 15 + 1) + 3 fits in 6 bits.
    localparam int HALF_W = 6;

    // Frame length in half-bit units: start, data and parity doubled, plus stop halves.
    function automatic logic [HALF_W-1:0] frame_halves(
        input logic [3:0] data_bits,
        input logic       parity_en,
        input logic [1:0] stop_halves
    );
        logic [HALF_W-1:0] whole;
        whole = HALF_W'(1) + HALF_W'(data_bits) + HALF_W'(parity_en);
        return (whole << 1) + HALF_W'(stop_halves);
    endfunction

endpackage

// File: rtl/lbd_edge.sv
module lbd_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev = level_i;
        rise_o    = level_i & ~st_q.prev;
        fall_o    = ~level_i & st_q.prev;
    end

    // Previous level resets low: a line high at reset release is not a fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/lbd_threshold.sv
module lbd_threshold #(
    parameter int CPB_W = 16,
    parameter int THR_W = CPB_W + lbd_pkg::HALF_W
) (
    input  logic [3:0]       data_bits_i,
    input  logic             parity_en_i,
    input  logic [1:0]       stop_halves_i,
    input  logic [CPB_W-1:0] clks_per_bit_i,
    output logic [THR_W-1:0] thr_o
);
    localparam int PROD_W = THR_W + 1;

    logic [lbd_pkg::HALF_W-1:0] halves;
    logic [PROD_W-1:0]          prod;

    always_comb begin
        halves = lbd_pkg::frame_halves(data_bits_i, parity_en_i, stop_halves_i);
        prod   = PROD_W'(halves) * PROD_W'(clks_per_bit_i);
        // Halve with round-up: ceil(prod / 2).
        thr_o  = THR_W'((prod + PROD_W'(1)) >> 1);
    end
endmodule

// File: rtl/lbd_low_timer.sv
module lbd_low_timer #(
    parameter int THR_W = 22
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             hit_o
);
    typedef struct packed {
        logic             active;
        logic [THR_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        hit_o = rise_i && st_q.active && (st_q.cnt >= thr_i);
        if (fall_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = THR_W'(1);
        end else if (rise_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active && (st_q.cnt < thr_i)) begin
            st_d.cnt = st_q.cnt + THR_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/line_break_detector.sv
module line_break_detector #(
    parameter int CPB_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_i,
    input  logic             invert_i,
    input  logic [3:0]       data_bits_i,
    input  logic             parity_en_i,
    input  logic [1:0]       stop_halves_i,
    input  logic [CPB_W-1:0] clks_per_bit_i,
    output logic             break_o,
    output logic             rx_idle_req_o
);
    localparam int THR_W = CPB_W + lbd_pkg::HALF_W;

    typedef struct packed {
        logic brk;
        logic idle_req;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic             level;
    logic             rise, fall, hit;
    logic [THR_W-1:0] thr;

    assign level = line_i ^ invert_i;

    lbd_edge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    lbd_threshold #(.CPB_W(CPB_W), .THR_W(THR_W)) u_thr (
        .data_bits_i    (data_bits_i),
        .parity_en_i    (parity_en_i),
        .stop_halves_i  (stop_halves_i),
        .clks_per_bit_i (clks_per_bit_i),
        .thr_o          (thr)
    );

    lbd_low_timer #(.THR_W(THR_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (rise),
        .fall_i (fall),
        .thr_i  (thr),
        .hit_o  (hit)
    );

    always_comb begin
        st_d.brk      = hit;
        st_d.idle_req = hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign break_o       = st_q.brk;
    assign rx_idle_req_o = st_q.idle_req;
endmodule

// File: rtl/line_break_detector_chk.sv
module line_break_detector_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic line_i,
    input logic invert_i,
    input logic break_o,
    input logic rx_idle_req_o
);
    p_single_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_o |=> !break_o);

    p_req_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_o == rx_idle_req_o);

    p_after_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_o |-> ($past(line_i ^ invert_i) && !$past(line_i ^ invert_i, 2)));

    p_quiet_while_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(line_i ^ invert_i) |-> !break_o);
endmodule

bind line_break_detector line_break_detector_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_i        (line_i),
    .invert_i      (invert_i),
    .break_o       (break_o),
    .rx_idle_req_o (rx_idle_req_o)
);

// File: tb/line_break_detector_tb_top.sv
module line_break_detector_tb_top;
    localparam int CPB_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_i = 1'b1;
    logic             invert_i = 1'b0;
    logic [3:0]       data_bits_i = 4'd8;
    logic             parity_en_i = 1'b0;
    logic [1:0]       stop_halves_i = 2'd1;
    logic [CPB_W-1:0] clks_per_bit_i = 16'd3;
    logic             break_o, rx_idle_req_o;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    line_break_detector #(.CPB_W(CPB_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .line_i         (line_i),
        .invert_i       (invert_i),
        .data_bits_i    (data_bits_i),
        .parity_en_i    (parity_en_i),
        .stop_halves_i  (stop_halves_i),
        .clks_per_bit_i (clks_per_bit_i),
        .break_o        (break_o),
        .rx_idle_req_o  (rx_idle_req_o)
    );

    // Behavioural reference: sample counter and index of the last fall.
    longint cyc = 0;
    longint fall_at = -1;
    bit     prev_lvl = 1'b0;
    bit     exp_brk = 1'b0;

    function automatic longint model_thr();
        real fb;
        fb = 1.0 + real'(data_bits_i) + (parity_en_i ? 1.0 : 0.0) + real'(stop_halves_i) * 0.5;
        return longint'($ceil(fb * real'(clks_per_bit_i)));
    endfunction

    always @(posedge clk) begin
        bit lvl;
        bit nxt;
        lvl = line_i ^ invert_i;
        if (!rst_n) begin
            prev_lvl = 1'b0;
            fall_at  = -1;
            nxt      = 1'b0;
        end else begin
            nxt = lvl && !prev_lvl && (fall_at >= 0) && ((cyc - fall_at) >= model_thr());
            if (lvl && !prev_lvl) fall_at = -1;
            if (!lvl && prev_lvl) fall_at = cyc;
            prev_lvl = lvl;
        end
        cyc++;
        exp_brk <= nxt;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(break_o == exp_brk, exp_brk ? "R2 pulse" : "R3 no pulse", break_o, exp_brk);
            check(rx_idle_req_o == exp_brk, "R6 idle request", rx_idle_req_o, exp_brk);
            if (break_o) pulses++;
        end
    end

    task automatic hold(input logic v, input int n);
        line_i = v;
        repeat (n) @(negedge clk);
    endtask

    // Run one low interval of len samples, then idle high, and check the pulse count.
    task automatic low_run(input int len, input int exp_pulses, input string tag);
        pulses = 0;
        hold(1'b0, len);
        hold(1'b1, 6);
        check(pulses == exp_pulses, tag, pulses, exp_pulses);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(break_o == 1'b0 && rx_idle_req_o == 1'b0, "R1 outputs in reset", break_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(break_o == 1'b0, "R1 first cycle after reset", break_o, 0);
        hold(1'b1, 4);

        // 8 data, no parity, half stop, 3 clocks/bit: T = ceil(9.5*3) = 29
        low_run(29, 1, "R2 exact threshold");
        low_run(28, 0, "R3 one below threshold");
        low_run(29, 1, "R5 single high cycle");

        // 9 data, parity, 1.5 stop, 5 clocks/bit: T = ceil(12.5*5) = 63
        data_bits_i = 4'd9; parity_en_i = 1'b1; stop_halves_i = 2'd3; clks_per_bit_i = 16'd5;
        hold(1'b1, 2);
        low_run(63, 1, "R4 parity 1.5 stop at T");
        low_run(62, 0, "R4 parity 1.5 stop at T-1");

        // 5 data, no parity, no stop, 4 clocks/bit: T = 24
        data_bits_i = 4'd5; parity_en_i = 1'b0; stop_halves_i = 2'd0; clks_per_bit_i = 16'd4;
        hold(1'b1, 2);
        low_run(24, 1, "R4 no stop at T");
        low_run(23, 0, "R4 no stop at T-1");

        // Back to T = 29: two short lows separated by a one-sample high
        data_bits_i = 4'd8; stop_halves_i = 2'd1; clks_per_bit_i = 16'd3;
        hold(1'b1, 2);
        pulses = 0;
        hold(1'b0, 20); hold(1'b1, 1); hold(1'b0, 20); hold(1'b1, 6);
        check(pulses == 0, "R7 rise clears measurement", pulses, 0);

        // Long low: quiet while low, one pulse on release
        pulses = 0;
        hold(1'b0, 2000);
        check(pulses == 0, "R11 no pulse while low", pulses, 0);
        hold(1'b1, 6);
        check(pulses == 1, "R9 long low one pulse", pulses, 1);

        // Inverted polarity: idle low on the pin, break is a long high
        invert_i = 1'b1; line_i = 1'b0;
        hold(1'b0, 4);
        pulses = 0;
        hold(1'b1, 29); hold(1'b0, 6);
        check(pulses == 1, "R8 inverted break", pulses, 1);
        pulses = 0;
        hold(1'b1, 28); hold(1'b0, 6);
        check(pulses == 0, "R8 inverted short", pulses, 0);
        invert_i = 1'b0; line_i = 1'b1;
        hold(1'b1, 4);

        // Line low through reset, released later: no pulse
        line_i = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
        hold(1'b0, 40); hold(1'b1, 6);
        check(pulses == 0, "R10 rise without fall", pulses, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule